// File: doc/BRIEF.md
# Windowed Alias Accumulator

This block takes a stream of complex samples. Each sample carries a slice number and a position inside a full-length slice. It scales both components of the sample by a window coefficient chosen by the position. It then folds the scaled sample into a half-length slice buffer. The buffer entry is addressed by the slice number and the low position bits, so a sample from the upper half of a slice lands on the same entry as its partner in the lower half. The entry is updated with a read-modify-write. Windowing and aliasing therefore take a single pass, and no full-length slice is ever stored.

Before a frame is accumulated, a clear sweep zeroes the whole buffer. The sweep also runs by itself after reset. When a slice is finished, a readout streams its half-length contents in address order to a downstream FFT. The defaults are small: 4 slices of 64 positions. Setting `POS_W` to 13 and `SLICE_W` to 3 gives 8 slices of 8192 points folded into 4096 entries each.

Top module: `alias_fold_acc`

## Requirements
- R1: The window coefficient for position p is c(p) = floor(k·(2^(COEF_W−1)−1)/H), where H = 2^(POS_W−1), k = p+1 for p < H, and k = 2H−p otherwise. This is a triangle whose peak, 2^(COEF_W−1)−1, sits at p = H−1 and p = H.
- R2: A sample updates buffer entry {slice, p[POS_W−2:0]}. Bit POS_W−1 of the position changes only the coefficient and never the entry. Entries of other slices are untouched.
- R3: Each component x is scaled as floor((x·c(p) + 2^(COEF_W−2)) / 2^(COEF_W−1)), which rounds half up. The result saturates to the signed DATA_W range.
- R4: The scaled value is added to the stored component and the sum is written back. The sum saturates at 2^(DATA_W−1)−1 and −2^(DATA_W−1).
- R5: Samples accepted on consecutive cycles, or one idle cycle apart, that hit the same entry give the same result as if they had been applied one at a time in arrival order.
- R6: After reset, and after a `clr_req` pulse while idle, `clr_busy` is high for exactly 2^(SLICE_W+POS_W−1) cycles and every entry then reads zero. Samples and readout requests presented while `clr_busy` is high are discarded.
- R7: A readout started by `rd_start` emits H words with `out_valid` high on consecutive cycles. The first word appears two cycles after the cycle in which `rd_start` is high. `out_idx` counts 0 to H−1, and `out_last` is high only on index H−1. `out_re` and `out_im` carry the entry contents (real part in the low half of each entry).
- R8: A `rd_start` pulse during an active readout is ignored: the stream continues unchanged and no second stream follows.
- R9: During and right after reset, `out_valid` is low and `clr_busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample present this cycle |
| in_slice | input | SLICE_W | Slice number of the sample |
| in_pos | input | POS_W | Position of the sample in the full-length slice |
| in_re | input | DATA_W | Real part, signed |
| in_im | input | DATA_W | Imaginary part, signed |
| clr_req | input | 1 | Start a clear sweep |
| clr_busy | output | 1 | Clear sweep in progress |
| rd_start | input | 1 | Start reading out a slice |
| rd_slice | input | SLICE_W | Slice to read out, taken when the readout starts |
| out_valid | output | 1 | Readout word valid |
| out_last | output | 1 | Final word of the readout |
| out_idx | output | POS_W-1 | Entry index of the readout word |
| out_re | output | DATA_W | Accumulated real part |
| out_im | output | DATA_W | Accumulated imaginary part |

## Verification
On every cycle, the assertions check how the readout is framed and how long a clear lasts. A stream starts at index 0 and increments without gaps. The last flag marks only the final index, and a stream falls silent once its clear is under way. A clear sweep lasts exactly one cycle per buffer entry. The arithmetic itself can only be shown by the bench scenarios. These cover the coefficient shape, rounding and saturation, aliasing of the two halves onto one entry, and forwarding for back-to-back hits on the same entry. The bench checks them by comparing read-out slices with a model that applies the same formulas in arrival order.

// File: rtl/alias_pkg.sv
package alias_pkg;

   typedef enum int {
      WIN_TRI  = 0,
      WIN_FLAT = 1
   } win_kind_e;

   // Coefficient for one position; evaluated on constants or a position bus.
   function automatic longint win_coef(win_kind_e kind, longint pos, longint half, longint cmax);
      longint k;
      if (kind == WIN_FLAT) return cmax;
      k = (pos < half) ? (pos + 1) : (2 * half - pos);
      return (k * cmax) / half;
   endfunction

endpackage

// File: rtl/alias_coef_rom.sv
module alias_coef_rom #(
   parameter int                  POS_W  = 6,
   parameter int                  COEF_W = 16,
   parameter alias_pkg::win_kind_e WINDOW = alias_pkg::WIN_TRI
) (
   input  logic [POS_W-1:0]  pos,
   output logic [COEF_W-1:0] coef
);
   localparam longint HALF = longint'(1) << (POS_W - 1);
   localparam longint CMAX = (longint'(1) << (COEF_W - 1)) - 1;

   logic [63:0] full;

   generate
      if (WINDOW == alias_pkg::WIN_FLAT) begin : g_flat
         assign full = 64'(CMAX);
      end else begin : g_tri
         always_comb begin
            full = 64'(alias_pkg::win_coef(alias_pkg::WIN_TRI, longint'({1'b0, pos}), HALF, CMAX));
         end
      end
   endgenerate

   assign coef = full[COEF_W-1:0];

   logic unused_hi;
   assign unused_hi = ^full[63:COEF_W];
endmodule

// File: rtl/alias_scale.sv
module alias_scale #(
   parameter int DATA_W = 32,
   parameter int COEF_W = 16,
   parameter int LANES  = 2,
   localparam int PW    = DATA_W + COEF_W + 1
) (
   input  logic                    clk,
   input  logic                    in_en,
   input  logic [LANES*DATA_W-1:0] x_flat,
   input  logic [COEF_W-1:0]       coef,
   output logic [LANES*PW-1:0]     p_flat
);
   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         logic signed [PW-1:0] p_q;
         always_ff @(posedge clk) begin
            if (in_en) p_q <= $signed(x_flat[l*DATA_W +: DATA_W]) * $signed({1'b0, coef});
         end
         assign p_flat[l*PW +: PW] = p_q;
      end
   endgenerate
endmodule

// File: rtl/alias_bank.sv
module alias_bank #(
   parameter int AW = 7,
   parameter int EW = 64,
   localparam int DEPTH = 1 << AW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_req,
   output logic          busy,
   input  logic          acc_rd_en,
   input  logic [AW-1:0] acc_rd_addr,
   output logic [EW-1:0] acc_rd_data,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [EW-1:0] wr_data,
   input  logic          out_rd_en,
   input  logic [AW-1:0] out_rd_addr,
   output logic [EW-1:0] out_rd_data
);
   logic [EW-1:0] mem [DEPTH];
   logic [AW-1:0] sweep;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b1;
         sweep <= '0;
      end else if (busy) begin
         sweep <= sweep + 1'b1;
         if (sweep == AW'(DEPTH - 1)) busy <= 1'b0;
      end else if (clr_req) begin
         busy  <= 1'b1;
         sweep <= '0;
      end
   end

   always_ff @(posedge clk) begin
      if (busy)       mem[sweep]   <= '0;
      else if (wr_en) mem[wr_addr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (acc_rd_en) acc_rd_data <= mem[acc_rd_addr];
   end

   always_ff @(posedge clk) begin
      if (out_rd_en) out_rd_data <= mem[out_rd_addr];
   end
endmodule

// File: rtl/alias_reader.sv
module alias_reader #(
   parameter int SLICE_W = 2,
   parameter int IDX_W   = 5
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [SLICE_W-1:0]       slice,
   input  logic                     busy,
   output logic                     rd_en,
   output logic [SLICE_W+IDX_W-1:0] rd_addr,
   output logic                     out_valid,
   output logic                     out_last,
   output logic [IDX_W-1:0]         out_idx
);
   localparam logic [IDX_W-1:0] LAST = '1;

   logic               active;
   logic [IDX_W-1:0]   ptr;
   logic [SLICE_W-1:0] sel;

   assign rd_en   = active && !busy;
   assign rd_addr = {sel, ptr};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active    <= 1'b0;
         ptr       <= '0;
         sel       <= '0;
         out_valid <= 1'b0;
         out_last  <= 1'b0;
         out_idx   <= '0;
      end else begin
         out_valid <= rd_en;
         out_last  <= rd_en && (ptr == LAST);
         out_idx   <= ptr;
         if (busy) begin
            active <= 1'b0;
         end else if (active) begin
            ptr <= ptr + 1'b1;
            if (ptr == LAST) active <= 1'b0;
         end else if (start) begin
            active <= 1'b1;
            ptr    <= '0;
            sel    <= slice;
         end
      end
   end
endmodule

// File: rtl/alias_fold_acc.sv
module alias_fold_acc #(
   parameter int                   SLICE_W = 2,
   parameter int                   POS_W   = 6,
   parameter int                   DATA_W  = 32,
   parameter int                   COEF_W  = 16,
   parameter alias_pkg::win_kind_e WINDOW  = alias_pkg::WIN_TRI
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic [SLICE_W-1:0]       in_slice,
   input  logic [POS_W-1:0]         in_pos,
   input  logic signed [DATA_W-1:0] in_re,
   input  logic signed [DATA_W-1:0] in_im,
   input  logic                     clr_req,
   output logic                     clr_busy,
   input  logic                     rd_start,
   input  logic [SLICE_W-1:0]       rd_slice,
   output logic                     out_valid,
   output logic                     out_last,
   output logic [POS_W-2:0]         out_idx,
   output logic signed [DATA_W-1:0] out_re,
   output logic signed [DATA_W-1:0] out_im
);
   localparam int IDX_W = POS_W - 1;
   localparam int AW    = SLICE_W + IDX_W;
   localparam int EW    = 2 * DATA_W;
   localparam int PW    = DATA_W + COEF_W + 1;
   localparam int SH    = COEF_W - 1;
   localparam logic [PW-1:0]     BIAS = {{(PW-1){1'b0}}, 1'b1} << (SH - 1);
   localparam logic [DATA_W-1:0] MAXV = {1'b0, {(DATA_W-1){1'b1}}};
   localparam logic [DATA_W-1:0] MINV = {1'b1, {(DATA_W-1){1'b0}}};

   generate
      if (POS_W < 2)                         begin : g_bad_pos   $error("POS_W must be at least 2"); end
      if (SLICE_W < 1)                       begin : g_bad_slice $error("SLICE_W must be at least 1"); end
      if (COEF_W < 3 || COEF_W > DATA_W)     begin : g_bad_coef  $error("COEF_W must lie in 3..DATA_W"); end
   endgenerate

   // Stage 0: accept, coefficient lookup, buffer read issue
   logic          accept;
   logic [AW-1:0] in_addr;
   logic [COEF_W-1:0] coef;

   assign accept  = in_valid && !clr_busy && !clr_req;
   assign in_addr = {in_slice, in_pos[IDX_W-1:0]};

   alias_coef_rom #(.POS_W(POS_W), .COEF_W(COEF_W), .WINDOW(WINDOW)) u_rom (
      .pos  (in_pos),
      .coef (coef)
   );

   logic [2*PW-1:0] prod_flat;

   alias_scale #(.DATA_W(DATA_W), .COEF_W(COEF_W), .LANES(2)) u_scale (
      .clk    (clk),
      .in_en  (accept),
      .x_flat ({in_im, in_re}),
      .coef   (coef),
      .p_flat (prod_flat)
   );

   // Stage 1: round, merge with stored value, write back
   logic          a_valid;
   logic [AW-1:0] a_addr;
   logic          wb_valid;
   logic [AW-1:0] wb_addr;
   logic [EW-1:0] wb_data;
   logic [EW-1:0] old_flat;
   logic [EW-1:0] sum_flat;
   logic          wr_en;
   logic          fwd_hit;

   assign wr_en   = a_valid && !clr_busy;
   assign fwd_hit = wb_valid && (wb_addr == a_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_valid  <= 1'b0;
         a_addr   <= '0;
         wb_valid <= 1'b0;
         wb_addr  <= '0;
         wb_data  <= '0;
      end else begin
         a_valid  <= accept;
         if (accept) a_addr <= in_addr;
         wb_valid <= wr_en;
         if (wr_en) begin
            wb_addr <= a_addr;
            wb_data <= sum_flat;
         end
      end
   end

   generate
      for (genvar l = 0; l < 2; l++) begin : g_lane
         logic signed [PW-1:0]   prod;
         logic signed [PW-1:0]   rnd;
         logic [PW-DATA_W:0]     hi;
         logic [DATA_W-1:0]      scaled;
         logic [DATA_W-1:0]      prev;
         logic [DATA_W:0]        wide;

         assign prod   = $signed(prod_flat[l*PW +: PW]);
         assign rnd    = (prod + $signed(BIAS)) >>> SH;
         assign hi     = rnd[PW-1:DATA_W-1];
         assign scaled = ((hi != '0) && (hi != '1)) ? (rnd[PW-1] ? MINV : MAXV)
                                                      : rnd[DATA_W-1:0];
         assign prev   = fwd_hit ? wb_data[l*DATA_W +: DATA_W] : old_flat[l*DATA_W +: DATA_W];
         assign wide   = {prev[DATA_W-1], prev} + {scaled[DATA_W-1], scaled};
         assign sum_flat[l*DATA_W +: DATA_W] =
            (wide[DATA_W] ^ wide[DATA_W-1]) ? (wide[DATA_W] ? MINV : MAXV) : wide[DATA_W-1:0];
      end
   endgenerate

   // Buffer and readout
   logic          rd_en;
   logic [AW-1:0] rd_addr;
   logic [EW-1:0] out_data;

   alias_bank #(.AW(AW), .EW(EW)) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_req     (clr_req),
      .busy        (clr_busy),
      .acc_rd_en   (accept),
      .acc_rd_addr (in_addr),
      .acc_rd_data (old_flat),
      .wr_en       (wr_en),
      .wr_addr     (a_addr),
      .wr_data     (sum_flat),
      .out_rd_en   (rd_en),
      .out_rd_addr (rd_addr),
      .out_rd_data (out_data)
   );

   alias_reader #(.SLICE_W(SLICE_W), .IDX_W(IDX_W)) u_reader (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (rd_start),
      .slice     (rd_slice),
      .busy      (clr_busy),
      .rd_en     (rd_en),
      .rd_addr   (rd_addr),
      .out_valid (out_valid),
      .out_last  (out_last),
      .out_idx   (out_idx)
   );

   assign out_re = out_data[DATA_W-1:0];
   assign out_im = out_data[EW-1:DATA_W];
endmodule

// File: rtl/alias_fold_acc_chk.sv
module alias_fold_acc_chk #(
   parameter int SLICE_W = 2,
   parameter int POS_W   = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clr_busy,
   input logic             out_valid,
   input logic             out_last,
   input logic [POS_W-2:0] out_idx
);
   localparam int IDX_W = POS_W - 1;
   localparam int AW    = SLICE_W + IDX_W;
   localparam int DEPTH = 1 << AW;

   logic [AW:0] bcnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        bcnt <= '0;
      else if (clr_busy) bcnt <= bcnt + 1'b1;
      else               bcnt <= '0;
   end

   AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid);                                                   // R7
   AST_LAST_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> (out_idx == '1));                                             // R7
   AST_FIRST_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> (out_idx == '0));                                     // R7
   AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(out_valid) && !$past(out_last)) |-> (out_idx == IDX_W'($past(out_idx) + 1'b1))); // R7
   AST_NO_RESTART_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |=> !out_valid);                                                  // R8
   AST_CLEAR_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      clr_busy |-> (bcnt < (AW+1)'(DEPTH)));                                     // R6
   AST_CLEAR_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clr_busy) |-> (bcnt == (AW+1)'(DEPTH)));                             // R6
   AST_QUIET_WHILE_CLEARING: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_busy && $past(clr_busy)) |-> !out_valid);                             // R6
endmodule

bind alias_fold_acc alias_fold_acc_chk #(.SLICE_W(SLICE_W), .POS_W(POS_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .clr_busy  (clr_busy),
   .out_valid (out_valid),
   .out_last  (out_last),
   .out_idx   (out_idx)
);

// File: tb/sim_alias_fold_acc.sv
`timescale 1ns/1ps
module sim_alias_fold_acc;
   localparam int SLICE_W = 2;
   localparam int POS_W   = 6;
   localparam int NSL     = 1 << SLICE_W;
   localparam int H       = 1 << (POS_W - 1);
   localparam int DEPTH   = NSL * H;
   localparam longint CMAX = 32767;
   localparam longint VMAX = 64'sd2147483647;
   localparam longint VMIN = -64'sd2147483648;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [SLICE_W-1:0] in_slice = '0;
   logic [POS_W-1:0]   in_pos = '0;
   logic signed [31:0] in_re = '0;
   logic signed [31:0] in_im = '0;
   logic clr_req = 1'b0;
   logic clr_busy;
   logic rd_start = 1'b0;
   logic [SLICE_W-1:0] rd_slice = '0;
   logic out_valid, out_last;
   logic [POS_W-2:0] out_idx;
   logic signed [31:0] out_re, out_im;

   int checks = 0;
   int errors = 0;
   longint mre [DEPTH];
   longint mim [DEPTH];

   always #10 clk = ~clk;

   alias_fold_acc #(.SLICE_W(SLICE_W), .POS_W(POS_W), .DATA_W(32), .COEF_W(16)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_slice(in_slice), .in_pos(in_pos),
      .in_re(in_re), .in_im(in_im), .clr_req(clr_req), .clr_busy(clr_busy),
      .rd_start(rd_start), .rd_slice(rd_slice), .out_valid(out_valid), .out_last(out_last),
      .out_idx(out_idx), .out_re(out_re), .out_im(out_im)
   );

   function automatic longint coef_exp(int p);
      longint k;
      k = (p < H) ? longint'(p + 1) : longint'(2 * H - p);
      return (k * CMAX) / H;
   endfunction

   function automatic longint sat32(longint v);
      if (v > VMAX) return VMAX;
      if (v < VMIN) return VMIN;
      return v;
   endfunction

   function automatic longint scale_exp(longint x, int p);
      return sat32((x * coef_exp(p) + 16384) >>> 15);
   endfunction

   task automatic check(bit ok, string req, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_zero();
      for (int i = 0; i < DEPTH; i++) begin mre[i] = 0; mim[i] = 0; end
   endtask

   // Called at a negedge; leaves in_valid low at the following negedge.
   task automatic send(int s, int p, longint re, longint im);
      int a;
      in_valid = 1'b1; in_slice = SLICE_W'(s); in_pos = POS_W'(p);
      in_re = re[31:0]; in_im = im[31:0];
      @(negedge clk);
      in_valid = 1'b0;
      a = s * H + (p % H);
      mre[a] = sat32(mre[a] + scale_exp(re, p));
      mim[a] = sat32(mim[a] + scale_exp(im, p));
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic read_slice(int s, string req);
      rd_slice = SLICE_W'(s); rd_start = 1'b1;
      @(negedge clk);
      rd_start = 1'b0;
      @(negedge clk);
      check(out_valid == 1'b1, "R7 first word latency", longint'(out_valid), 1);
      for (int i = 0; i < H; i++) begin
         check(out_valid && out_idx == (POS_W-1)'(i), "R7 index order", longint'(out_idx), i);
         check(out_last == (i == H - 1), "R7 last flag", longint'(out_last), longint'(i == H - 1));
         check(longint'(out_re) == mre[s*H+i], {req, " real"}, longint'(out_re), mre[s*H+i]);
         check(longint'(out_im) == mim[s*H+i], {req, " imag"}, longint'(out_im), mim[s*H+i]);
         if (i == 4) begin rd_start = 1'b1; rd_slice = SLICE_W'((s + 1) % NSL); end
         else        rd_start = 1'b0;
         @(negedge clk);
      end
      rd_start = 1'b0;
      for (int i = 0; i < 4; i++) begin
         check(out_valid == 1'b0, "R8 ignored start", longint'(out_valid), 0);
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int s, p, bc;
      void'($urandom(32'd20240611));
      model_zero();
      idle(3);
      check(out_valid == 1'b0, "R9 out_valid in reset", longint'(out_valid), 0);
      check(clr_busy == 1'b1, "R9 clr_busy in reset", longint'(clr_busy), 1);
      rst_n = 1'b1;
      @(negedge clk);
      check(clr_busy == 1'b1, "R9 clear after reset", longint'(clr_busy), 1);
      check(out_valid == 1'b0, "R9 quiet after reset", longint'(out_valid), 0);
      bc = 1;
      while (clr_busy && bc < 2 * DEPTH) begin @(negedge clk); bc++; end
      check(bc == DEPTH, "R6 reset sweep length", bc, DEPTH);

      // R1: unit sample exposes the coefficient directly
      for (int i = 0; i < H; i++) send(0, i, 32768, -32768);
      for (int i = 0; i < H; i++) send(2, H + i, 32768, 0);
      idle(3);
      for (int i = 0; i < H; i++)
         check(mre[i] == coef_exp(i), "R1 model coefficient", mre[i], coef_exp(i));
      read_slice(0, "R1 low half");
      read_slice(2, "R1 high half");

      // R2/R5: both halves onto one entry, back to back
      send(1, 3, 1000, -777);
      send(1, 3 + H, 2000, 555);
      send(1, 3, -50, 12);
      idle(1);
      send(1, 3 + H, 7, 7);
      idle(3);
      read_slice(1, "R2 R5 alias fold");
      read_slice(3, "R2 untouched slice");

      // R4: saturation on repeated peak-coefficient hits
      for (int i = 0; i < 4; i++) send(1, H - 1, VMAX, VMIN);
      idle(3);
      check(mre[H+H-1] == VMAX, "R4 model saturates", mre[H+H-1], VMAX);
      read_slice(1, "R4 saturation");

      // R3: rounding of small values
      send(3, H - 1, 1, -1);
      send(3, 0, 16, -16);
      send(3, 1, 33, -33);
      send(3, H, 3, -3);
      idle(3);
      read_slice(3, "R3 rounding");

      // Constrained random accumulation with address reuse
      s = 0; p = 0;
      for (int n = 0; n < 400; n++) begin
         if ($urandom % 4 != 0) begin
            s = int'($urandom % NSL);
            p = int'($urandom % (2 * H));
         end else if ($urandom % 2 == 0) begin
            p = p ^ H;
         end
         send(s, p, longint'($signed($urandom)), longint'($signed($urandom)));
         if ($urandom % 5 == 0) idle(1);
      end
      idle(3);
      for (int i = 0; i < NSL; i++) read_slice(i, "R5 random accumulate");

      // R6: clear sweep, samples and reads during it are dropped
      clr_req = 1'b1;
      @(negedge clk);
      clr_req = 1'b0;
      bc = 0;
      while (clr_busy && bc < 2 * DEPTH) begin
         in_valid = 1'b1; in_slice = SLICE_W'(bc % NSL); in_pos = POS_W'(bc % (2 * H));
         in_re = 32'sd123456; in_im = -32'sd99;
         rd_start = (bc == 10);
         @(negedge clk);
         if (bc > 0) check(out_valid == 1'b0, "R6 no readout while clearing", longint'(out_valid), 0);
         bc++;
      end
      in_valid = 1'b0; rd_start = 1'b0;
      check(bc == DEPTH, "R6 sweep length", bc, DEPTH);
      model_zero();
      idle(2);
      for (int i = 0; i < NSL; i++) read_slice(i, "R6 cleared");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule